// File: doc/BRIEF.md
# Sub-block Run-Length Coefficient Encoder

This block turns the quantised coefficients of one macroblock's sub-blocks into a compact byte stream. Coefficients arrive one per accepted beat in scan order, tagged with a sub-block index from 0 to 5. A flag marks the final beat of each sub-block. The block stores the whole sub-block before it emits anything. This tells it whether any coefficient is non-zero, and it can skip sub-blocks that are entirely zero.

For every coded sub-block the output carries a header byte with the sub-block number. Pairs of bytes follow: a count of zero coefficients, then the next non-zero coefficient. A terminating pair closes the sub-block. Its count byte has both top bits set and counts the zeros before the final scan position. Its coefficient byte always carries the final position's value, even when that value is zero.

Each output byte comes with a two-bit kind tag. Bytes move under a valid/ready handshake. A data strobe pulses only on cycles that transfer a byte, so idle or stalled cycles produce no pulse. Input values too wide for a signed byte are clamped, and a flag pulse marks each clamp.

Top module: `rlc_subblock_encoder`

## Requirements
- R1: The first byte of a coded sub-block has kind 0. It holds the sub-block index plus one (1 to 6) on bits 2:0, with bits 7:3 zero.
- R2: A sub-block whose clamped coefficients are all zero produces no output byte.
- R3: For each non-zero coefficient at scan positions 0 to DEPTH-2, the block emits two bytes:
  - a kind-1 byte with bits 7:6 = 00 and, on bits 5:0, the number of zero coefficients since the previous emitted coefficient (or since the start of the sub-block);
  - then a kind-2 byte holding the coefficient as two's complement. This byte is never zero.
- R4: A coded sub-block always ends with two bytes:
  - a kind-1 byte with bits 7:6 = 11 and, on bits 5:0, the number of zeros between the last emitted coefficient and position DEPTH-1;
  - then a kind-2 byte holding the coefficient at position DEPTH-1, which may be zero.
- R5: Input values above 127 become 127 and values below -128 become -128. `sat_hit` is high for exactly the one cycle after each clamped beat is accepted.
- R6: Asserting `in_last` on a beat ends the sub-block there. Every later scan position counts as zero.
- R7: While `out_valid` is high and `out_ready` low, `out_valid`, `out_byte` and `out_kind` hold. `out_strobe` is high exactly on cycles with both `out_valid` and `out_ready` high.
- R8: `in_ready` is low while any output byte is pending. It is also low on the cycle after a sub-block's final beat is accepted.
- R9: After synchronous reset, `out_valid` and `sat_hit` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Coefficient beat offered |
| in_ready | output | 1 | Beat accepted when high together with in_valid |
| in_coef | input | COEF_W | Signed quantised coefficient |
| in_blk | input | 3 | Sub-block index 0 to 5 |
| in_last | input | 1 | Final beat of this sub-block |
| sat_hit | output | 1 | Pulse: the previous accepted beat was clamped |
| out_valid | output | 1 | Output byte available |
| out_ready | input | 1 | Downstream takes the byte |
| out_byte | output | 8 | Encoded byte |
| out_kind | output | 2 | 0 header, 1 run count, 2 coefficient |
| out_strobe | output | 1 | Pulses on each transferred byte |

## Verification
Several kinds of internal fault show up in the very next sub-block's output:
- A wrong scan pointer or run counter appears as a count byte that disagrees with the arithmetic zero count.
- A stale length register turns positions past an early end into spurious coefficient bytes.
- A lost non-zero accumulator either drops a sub-block or emits a header for an empty one.

The bench compares every transferred byte against a stream computed from the input values. It sweeps a single non-zero value across every scan position and runs sparse random patterns under random backpressure. A faulty pointer, count or length therefore produces a mismatched byte within one sub-block of the fault.

// File: rtl/rlc_pkg.sv
package rlc_pkg;

    localparam int BYTE_W = 8;
    localparam int RUN_W  = 6;
    localparam int BLK_W  = 3;

    localparam logic [1:0] RUN_MID = 2'b00;
    localparam logic [1:0] RUN_END = 2'b11;

    typedef enum logic [1:0] {
        KIND_NUM  = 2'd0,
        KIND_RUN  = 2'd1,
        KIND_COEF = 2'd2
    } kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NUM,
        ST_SCAN,
        ST_RUN,
        ST_COEF,
        ST_ERUN,
        ST_ECOEF
    } emit_state_t;

    typedef struct packed {
        kind_t              kind;
        logic [BYTE_W-1:0]  data;
    } beat_t;

    function automatic logic [BYTE_W-1:0] num_byte(input logic [BLK_W-1:0] blk);
        return {{(BYTE_W-BLK_W){1'b0}}, blk + 3'd1};
    endfunction

    function automatic logic [BYTE_W-1:0] run_byte(input logic is_end, input logic [RUN_W-1:0] cnt);
        return {(is_end ? RUN_END : RUN_MID), cnt};
    endfunction

endpackage

// File: rtl/rlc_capture.sv
module rlc_capture
    import rlc_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int COEF_W = 12,
    parameter int IDX_W  = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic signed [COEF_W-1:0] in_coef,
    input  logic [BLK_W-1:0]         in_blk,
    input  logic                     in_last,
    input  logic                     hold,
    input  logic [IDX_W-1:0]         rd_addr,
    output logic [BYTE_W-1:0]        rd_data,
    output logic                     done,
    output logic                     done_nz,
    output logic [BLK_W-1:0]         done_blk,
    output logic                     sat_hit
);

    localparam logic signed [COEF_W-1:0] HI = COEF_W'(127);
    localparam logic signed [COEF_W-1:0] LO = COEF_W'(-128);
    localparam logic [IDX_W-1:0]         WR_TOP = IDX_W'(DEPTH - 1);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  wr;
    logic [IDX_W:0]    len_q;
    logic              nz_acc;
    logic [BYTE_W-1:0] sat_val;
    logic              clamped;
    logic              accept;
    logic              final_beat;

    assign in_ready   = !hold && !done;
    assign accept     = in_valid && in_ready;
    assign final_beat = in_last || (wr == WR_TOP);

    always_comb begin
        clamped = 1'b0;
        if (in_coef > HI) begin
            sat_val = 8'h7F;
            clamped = 1'b1;
        end else if (in_coef < LO) begin
            sat_val = 8'h80;
            clamped = 1'b1;
        end else begin
            sat_val = in_coef[BYTE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wr] <= sat_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr       <= '0;
            len_q    <= '0;
            nz_acc   <= 1'b0;
            done     <= 1'b0;
            done_nz  <= 1'b0;
            done_blk <= '0;
            sat_hit  <= 1'b0;
        end else begin
            done    <= 1'b0;
            sat_hit <= accept && clamped;
            if (accept) begin
                if (final_beat) begin
                    wr       <= '0;
                    nz_acc   <= 1'b0;
                    done     <= 1'b1;
                    done_nz  <= nz_acc || (sat_val != '0);
                    done_blk <= in_blk;
                    len_q    <= (IDX_W+1)'(wr) + 1'b1;
                end else begin
                    wr     <= wr + 1'b1;
                    nz_acc <= nz_acc || (sat_val != '0);
                end
            end
        end
    end

    assign rd_data = ({1'b0, rd_addr} < len_q) ? mem[rd_addr] : '0;

endmodule

// File: rtl/rlc_emitter.sv
module rlc_emitter
    import rlc_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IDX_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [BLK_W-1:0]   start_blk,
    output logic [IDX_W-1:0]   rd_addr,
    input  logic [BYTE_W-1:0]  rd_data,
    output logic               busy,
    output logic               out_valid,
    input  logic               out_ready,
    output beat_t              beat
);

    localparam logic [IDX_W-1:0] P_LAST = IDX_W'(DEPTH - 1);

    emit_state_t       st;
    logic [IDX_W-1:0]  pos;
    logic [RUN_W-1:0]  run;
    logic [BLK_W-1:0]  blk;
    logic              fire;

    assign rd_addr = pos;
    assign busy    = (st != ST_IDLE);
    assign fire    = out_valid && out_ready;

    always_comb begin
        out_valid = 1'b0;
        beat      = '{kind: KIND_NUM, data: '0};
        case (st)
            ST_NUM: begin
                out_valid = 1'b1;
                beat      = '{kind: KIND_NUM, data: num_byte(blk)};
            end
            ST_RUN: begin
                out_valid = 1'b1;
                beat      = '{kind: KIND_RUN, data: run_byte(1'b0, run)};
            end
            ST_ERUN: begin
                out_valid = 1'b1;
                beat      = '{kind: KIND_RUN, data: run_byte(1'b1, run)};
            end
            ST_COEF, ST_ECOEF: begin
                out_valid = 1'b1;
                beat      = '{kind: KIND_COEF, data: rd_data};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            pos <= '0;
            run <= '0;
            blk <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    st  <= ST_NUM;
                    blk <= start_blk;
                    pos <= '0;
                    run <= '0;
                end
                ST_NUM: if (fire) st <= ST_SCAN;
                ST_SCAN: begin
                    if (pos == P_LAST) begin
                        st <= ST_ERUN;
                    end else if (rd_data != '0) begin
                        st <= ST_RUN;
                    end else begin
                        pos <= pos + 1'b1;
                        run <= run + 1'b1;
                    end
                end
                ST_RUN: if (fire) st <= ST_COEF;
                ST_COEF: if (fire) begin
                    st  <= ST_SCAN;
                    pos <= pos + 1'b1;
                    run <= '0;
                end
                ST_ERUN: if (fire) st <= ST_ECOEF;
                ST_ECOEF: if (fire) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rlc_subblock_encoder.sv
module rlc_subblock_encoder
    import rlc_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int COEF_W = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic signed [COEF_W-1:0] in_coef,
    input  logic [2:0]               in_blk,
    input  logic                     in_last,
    output logic                     sat_hit,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [7:0]               out_byte,
    output logic [1:0]               out_kind,
    output logic                     out_strobe
);

    localparam int IDX_W = $clog2(DEPTH);

    logic [IDX_W-1:0]  rd_addr;
    logic [BYTE_W-1:0] rd_data;
    logic              done;
    logic              done_nz;
    logic [BLK_W-1:0]  done_blk;
    logic              busy;
    beat_t             beat;

    rlc_capture #(.DEPTH(DEPTH), .COEF_W(COEF_W), .IDX_W(IDX_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_coef  (in_coef),
        .in_blk   (in_blk),
        .in_last  (in_last),
        .hold     (busy),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .done     (done),
        .done_nz  (done_nz),
        .done_blk (done_blk),
        .sat_hit  (sat_hit)
    );

    rlc_emitter #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_emit (
        .clk       (clk),
        .rst       (rst),
        .start     (done && done_nz),
        .start_blk (done_blk),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .busy      (busy),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .beat      (beat)
    );

    assign out_byte   = beat.data;
    assign out_kind   = beat.kind;
    assign out_strobe = out_valid && out_ready;

endmodule

// File: rtl/rlc_checker.sv
module rlc_checker (
    input logic       clk,
    input logic       rst,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_byte,
    input logic [1:0] out_kind,
    input logic       out_strobe
);

    logic want_coef;
    logic end_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            want_coef <= 1'b0;
            end_seen  <= 1'b0;
        end else if (out_strobe) begin
            if (out_kind == 2'd1) begin
                want_coef <= 1'b1;
                end_seen  <= (out_byte[7:6] == 2'b11);
            end else begin
                want_coef <= 1'b0;
            end
        end
    end

    assert_num_range_R1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == 2'd0) |-> (out_byte[7:3] == 5'd0 && out_byte[2:0] != 3'd0 && out_byte[2:0] <= 3'd6));

    assert_run_form_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == 2'd1) |-> (out_byte[7:6] == 2'b00 || out_byte[7:6] == 2'b11));

    assert_coef_follows_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && want_coef) |-> (out_kind == 2'd2));

    assert_coef_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == 2'd2 && !end_seen) |-> (out_byte != 8'd0));

    assert_kind_legal_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_kind != 2'd3));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_kind)));

    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !out_valid);

endmodule

bind rlc_subblock_encoder rlc_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_byte   (out_byte),
    .out_kind   (out_kind),
    .out_strobe (out_strobe)
);

// File: tb/sim_rlc_subblock_encoder.sv
module sim_rlc_subblock_encoder;

    localparam int DEPTH  = 64;
    localparam int COEF_W = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_ready;
    logic signed [COEF_W-1:0] in_coef = '0;
    logic [2:0] in_blk = '0;
    logic in_last = 1'b0;
    logic sat_hit;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [7:0] out_byte;
    logic [1:0] out_kind;
    logic out_strobe;

    always #5 clk = ~clk;

    rlc_subblock_encoder #(.DEPTH(DEPTH), .COEF_W(COEF_W)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_coef(in_coef), .in_blk(in_blk), .in_last(in_last), .sat_hit(sat_hit),
        .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
        .out_kind(out_kind), .out_strobe(out_strobe)
    );

    int tests = 0;
    int fails = 0;
    int coefs [DEPTH];
    int got_q [$];
    int sat_seen = 0;
    bit hold_err = 0;
    bit overlap_err = 0;
    bit bp_on = 0;
    logic [31:0] rng = 32'h1234_5678;
    logic [31:0] rdy_rng = 32'h0BAD_F00D;

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    function automatic int clamp8(input int v);
        if (v > 127) return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    // backpressure driver
    initial begin
        forever begin
            @(negedge clk);
            #1;
            rdy_rng = nxt(rdy_rng);
            out_ready = bp_on ? rdy_rng[3] : 1'b1;
        end
    end

    // output monitor
    initial begin
        bit   stall_prev = 0;
        logic [7:0] byte_prev = '0;
        logic [1:0] kind_prev = '0;
        forever begin
            @(negedge clk);
            #2;
            if (!rst) begin
                if (out_valid && out_ready) got_q.push_back(int'(out_kind) * 256 + int'(out_byte));
                if (sat_hit) sat_seen++;
                if (in_ready && out_valid) overlap_err = 1;
                if (out_strobe != (out_valid && out_ready)) hold_err = 1;
                if (stall_prev && !(out_valid && out_byte == byte_prev && out_kind == kind_prev)) hold_err = 1;
                stall_prev = out_valid && !out_ready;
                byte_prev  = out_byte;
                kind_prev  = out_kind;
            end
        end
    end

    task automatic check_stream(input int idx, input int len, input string req);
        int exp_q [$];
        int run;
        int s [DEPTH];
        bit any;
        any = 0;
        for (int i = 0; i < DEPTH; i++) begin
            s[i] = (i < len) ? clamp8(coefs[i]) : 0;
            if (s[i] != 0) any = 1;
        end
        if (any) begin
            exp_q.push_back(idx + 1);                   // R1 header
            run = 0;
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (s[i] == 0) run++;
                else begin
                    exp_q.push_back(256 + run);         // R3 run byte
                    exp_q.push_back(512 + (s[i] & 255));
                    run = 0;
                end
            end
            exp_q.push_back(256 + 192 + run);           // R4 end marker
            exp_q.push_back(512 + (s[DEPTH-1] & 255));
        end
        tests++;
        if (got_q.size() != exp_q.size()) begin
            fails++;
            $display("FAIL %s%s: blk %0d byte count actual %0d expected %0d",
                     req, any ? "" : "/R2", idx, got_q.size(), exp_q.size());
        end else begin
            for (int i = 0; i < exp_q.size(); i++) begin
                if (got_q[i] != exp_q[i]) begin
                    fails++;
                    $display("FAIL %s%s: blk %0d byte %0d actual %h expected %h", req,
                             (i == 0) ? "/R1" : (i >= exp_q.size() - 2) ? "/R4" : "/R3",
                             idx, i, got_q[i], exp_q[i]);
                    break;
                end
            end
        end
    endtask

    task automatic run_block(input int idx, input int len, input string req);
        int exp_sat;
        got_q.delete();
        sat_seen = 0;
        exp_sat = 0;
        for (int i = 0; i < len; i++) begin
            if (coefs[i] != clamp8(coefs[i])) exp_sat++;
            do begin
                @(negedge clk);
                #1;
                in_valid = 1'b1;
                in_coef  = COEF_W'(coefs[i]);
                in_blk   = 3'(idx);
                in_last  = (i == len - 1);
                #1;
            end while (!in_ready);
        end
        @(negedge clk);
        #1;
        in_valid = 1'b0;
        in_last  = 1'b0;
        #2;
        tests++;
        if (in_ready) begin
            fails++;
            $display("FAIL R8: in_ready after final beat actual 1 expected 0");
        end
        while (!in_ready) begin
            @(negedge clk);
            #3;
        end
        check_stream(idx, len, req);
        tests++;
        if (sat_seen != exp_sat) begin
            fails++;
            $display("FAIL R5: blk %0d clamp pulses actual %0d expected %0d", idx, sat_seen, exp_sat);
        end
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        rst = 1'b0;
        #1;
        // R9 reset state
        tests++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1 || sat_hit !== 1'b0) begin
            fails++;
            $display("FAIL R9: valid/ready/sat actual %b%b%b expected 010", out_valid, in_ready, sat_hit);
        end

        // R2 all-zero sub-block
        for (int i = 0; i < DEPTH; i++) coefs[i] = 0;
        run_block(2, DEPTH, "R2");

        // R3/R4 single non-zero swept over every position
        for (int p = 0; p < DEPTH; p++) begin
            bp_on = p[0];
            for (int i = 0; i < DEPTH; i++) coefs[i] = 0;
            coefs[p] = p[1] ? -(p + 1) : (p + 1);
            run_block(p % 6, DEPTH, (p == DEPTH - 1) ? "R4" : "R3");
        end

        // R3 dense sub-block
        bp_on = 0;
        for (int i = 0; i < DEPTH; i++) coefs[i] = (i % 2 == 0) ? i + 1 : -(i + 1);
        run_block(5, DEPTH, "R3");

        // R5 clamping at the range edges
        for (int i = 0; i < DEPTH; i++) coefs[i] = 0;
        coefs[0] = 127;  coefs[1] = 128;  coefs[2] = -128; coefs[3] = -129;
        coefs[7] = 2047; coefs[9] = -2048; coefs[DEPTH-1] = 300;
        run_block(1, DEPTH, "R5");

        // R6 early end: later positions count as zero
        for (int i = 0; i < DEPTH; i++) coefs[i] = 9;
        coefs[0] = 0; coefs[1] = 0; coefs[3] = 0;
        run_block(0, 5, "R6");
        for (int i = 0; i < DEPTH; i++) coefs[i] = 0;
        run_block(4, 1, "R6");
        coefs[0] = -3;
        run_block(3, 1, "R6");

        // R7 random sparse patterns under backpressure
        bp_on = 1;
        for (int b = 0; b < 30; b++) begin
            int len;
            for (int i = 0; i < DEPTH; i++) begin
                rng = nxt(rng);
                coefs[i] = (rng[1:0] == 2'b00) ? int'(rng[31:8] % 401) - 200 : 0;
            end
            rng = nxt(rng);
            len = (b % 5 == 4) ? int'(rng % DEPTH) + 1 : DEPTH;
            run_block(b % 6, len, "R7");
        end
        bp_on = 0;

        tests++;
        if (hold_err) begin
            fails++;
            $display("FAIL R7: output hold/strobe violation actual 1 expected 0");
        end
        tests++;
        if (overlap_err) begin
            fails++;
            $display("FAIL R8: in_ready while output pending actual 1 expected 0");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule